// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds all of the registers a host programs in a four-channel DMA controller. The host reaches it over an 8-bit data path with a 4-bit register index, an active-low select and separate active-low read and write strobes. Each channel has a 16-bit starting address, a 16-bit working address, a 16-bit starting count and a 16-bit working count. A single pointer flip-flop chooses the low or high byte of all of them. Other addresses carry the global command, software request, mask, status, per-channel mode and temporary data registers. Some addresses act as commands: they fire when the host reads or writes them.

A separate transfer sequencer drives the block. It names a channel, and it pulses `xfer_step` once per completed transfer or `xfer_abort` when a cycle is cut short. The bank then moves the working address, counts the word count down, detects the terminal count, and reloads the working values from the starting values when a channel is set to re-arm itself. The sequencer reads the selected channel's working address, count and mode from the bank, together with the command, mask and software request bits.

Top module: `dma_regbank`

## Requirements
- R1: Reset, or a write to index 0xD, sets all four mask bits and clears the command, status, software request and temporary registers, the byte pointer and the mode-read counter. Reset also clears the channel and mode registers.
- R2: The byte pointer selects the low byte (0) or high byte (1). It toggles after every host read or write of indexes 0x0 to 0x7. A write to 0xC clears it and a read of 0xC sets it.
- R3: Index 2c holds the address of channel c and index 2c+1 holds its count. A write loads the selected byte of both the starting and the working value. A read returns the selected byte of the working value.
- R4: Any register side effect occurs on the first clock edge at which the strobe is seen low with select low. Holding a strobe low over several clocks performs exactly one action.
- R5: A write to 0xB stores data bits [7:2] as the mode of the channel named by data bits [1:0]. A read of 0xE resets the mode-read counter. Each read of 0xB returns {mode[counter], 2'b11} and then advances the counter from 0 up to 3.
- R6: A write to 0x9 sets or clears the software request bit of channel data[1:0] to the value of data[2], and a read of 0x9 returns {4'b1111, request}. A write to 0xA does the same on the mask bit. A write to 0xE clears the mask. Index 0xF writes mask = data[3:0] and reads {4'b1111, mask}. A write to 0x8 loads the command register and a read of 0xA returns it.
- R7: A read of 0x8 returns status, with the terminal-count flags of channels 0 to 3 in bits [3:0] and the raw `req_lvl` inputs in bits [7:4]. The read clears the terminal-count flags.
- R8: On `xfer_step` the working address moves by one, downward when mode bit 3 (data bit 5 when written) is set and upward otherwise. It does not move for channel 0 when command bits 0 and 1 are both set.
- R9: On `xfer_step` the working count decrements. A step taken at count 0 is a terminal count: `tc_pulse` is high in that cycle, the count wraps to 0xFFFF and the channel's status flag is set.
- R10: When mode bit 2 (data bit 4 when written) is set, a terminal count or an `xfer_abort` reloads the working address and count from the starting values. An abort also sets the channel's status flag.
- R11: With command bit 0 set, a terminal count or abort on channel 0 or 1 sets only status bit 1.
- R12: `tmp_we` loads `tmp_din` into the temporary register, and a read of 0xD returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Register select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 4 | Register index |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the current index |
| req_lvl | input | 4 | Raw request levels shown in status |
| xfer_ch | input | 2 | Channel that the sequencer is serving |
| xfer_step | input | 1 | One transfer completed on xfer_ch |
| xfer_abort | input | 1 | Cycle on xfer_ch ended early |
| tmp_we | input | 1 | Load the temporary register |
| tmp_din | input | 8 | Data for the temporary register |
| xfer_addr | output | 16 | Working address of xfer_ch |
| xfer_cnt | output | 16 | Working count of xfer_ch |
| xfer_mode | output | 6 | Mode of xfer_ch |
| tc_pulse | output | 1 | Terminal count on this step |
| cmd_q | output | 8 | Command register |
| mask_q | output | 4 | Mask register |
| swreq_q | output | 4 | Software request register |

## Verification
The assertions assume that the sequencer never pulses `xfer_step` and `xfer_abort` in the same cycle. They also assume that a host access with both strobes low does not occur, and that `xfer_ch` is stable while a pulse is high. The bench drives every input on the falling clock edge. Each host access sets only one strobe, and a step or abort pulse lasts one cycle with the channel already set up. Host accesses are never issued in the same cycle as a step on the channel they touch, so the point at which a bus write takes priority never has to be tested.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // insert a byte into the low or high half of a word
  function automatic word_t put_byte(input word_t v, input logic hi, input byte_t b);
    word_t r;
    r = v;
    if (hi) r[WORD_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  function automatic byte_t get_byte(input word_t v, input logic hi);
    return hi ? v[WORD_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic word_t addr_next(input word_t a, input logic down, input logic hold);
    if (hold) return a;
    return down ? a - word_t'(1) : a + word_t'(1);
  endfunction

  // stored mode bit positions (written data bits minus two)
  localparam int M_AUTO = 2;
  localparam int M_DOWN = 3;
endpackage

// File: rtl/dma_busdec.sv
module dma_busdec #(
  parameter int AW = 4,
  localparam int NREG = 1 << AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] wr_hit,
  output logic [NREG-1:0] rd_hit
);
  logic wr_lvl, rd_lvl, wr_prev, rd_prev, wr_fire, rd_fire;

  assign wr_lvl  = !cs_n && !wr_n;
  assign rd_lvl  = !cs_n && !rd_n && wr_n;
  assign wr_fire = wr_lvl && !wr_prev;
  assign rd_fire = rd_lvl && !rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_prev <= wr_lvl;
      rd_prev <= rd_lvl;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = wr_fire && (addr == AW'(i));
    assign rd_hit[i] = rd_fire && (addr == AW'(i));
  end

  a_r4_one_write: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire);
  a_r4_one_read: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> !rd_fire);
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_hit, rd_hit}));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_regbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we_addr,
  input  logic  we_cnt,
  input  logic  bp_hi,
  input  byte_t wbyte,
  input  logic  step,
  input  logic  abort,
  input  logic  autoinit,
  input  logic  down,
  input  logic  hold,
  output word_t cur_addr,
  output word_t cur_cnt,
  output logic  tc_now
);
  word_t base_addr, base_cnt;
  logic  reload;

  assign tc_now = step && (cur_cnt == '0);
  assign reload = autoinit && (tc_now || abort);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (we_addr) begin
      base_addr <= put_byte(base_addr, bp_hi, wbyte);
      cur_addr  <= put_byte(cur_addr, bp_hi, wbyte);
    end else if (reload) begin
      cur_addr <= base_addr;
    end else if (step) begin
      cur_addr <= addr_next(cur_addr, down, hold);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
    end else if (we_cnt) begin
      base_cnt <= put_byte(base_cnt, bp_hi, wbyte);
      cur_cnt  <= put_byte(cur_cnt, bp_hi, wbyte);
    end else if (reload) begin
      cur_cnt <= base_cnt;
    end else if (step) begin
      cur_cnt <= cur_cnt - word_t'(1);
    end
  end

  a_r8_addr_up: assert property (@(posedge clk) disable iff (rst)
    (step && !we_addr && !reload && !down && !hold) |=> cur_addr == $past(cur_addr) + word_t'(1));
  a_r8_addr_held: assert property (@(posedge clk) disable iff (rst)
    (step && !we_addr && !reload && hold) |=> $stable(cur_addr));
  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    (tc_now && !autoinit && !we_cnt) |=> cur_cnt == '1);
  a_r10_reload: assert property (@(posedge clk) disable iff (rst)
    (reload && !we_addr) |=> cur_addr == $past(base_addr));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4,
  localparam int CW   = $clog2(NCH),
  localparam int NREG = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [AW-1:0]        addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    rdata,
  input  logic [NCH-1:0]       req_lvl,
  input  logic [CW-1:0]        xfer_ch,
  input  logic                 xfer_step,
  input  logic                 xfer_abort,
  input  logic                 tmp_we,
  input  logic [BYTE_W-1:0]    tmp_din,
  output logic [WORD_W-1:0]    xfer_addr,
  output logic [WORD_W-1:0]    xfer_cnt,
  output logic [BYTE_W-3:0]    xfer_mode,
  output logic                 tc_pulse,
  output logic [BYTE_W-1:0]    cmd_q,
  output logic [NCH-1:0]       mask_q,
  output logic [NCH-1:0]       swreq_q
);
  // register indexes whose behaviour is fixed by the host map
  localparam int IX_STAT = 8, IX_REQ = 9, IX_MBIT = 10, IX_MODE = 11;
  localparam int IX_PTR = 12, IX_TMP = 13, IX_MCLR = 14, IX_MASK = 15;

  logic [NREG-1:0] wr_hit, rd_hit;
  logic            bp, mclr, wipe, chan_touch;
  logic [CW-1:0]   mode_ptr;
  logic [NCH-1:0]  tc_q, tc_raw, tc_set;
  byte_t           tmp_q;
  logic [BYTE_W-3:0] mode_q [NCH];
  word_t           ca [NCH];
  word_t           cc [NCH];
  logic [CW-1:0]   wsel;

  dma_busdec #(.AW(AW)) u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  assign mclr       = wr_hit[IX_TMP];
  assign wipe       = rst || mclr;
  assign chan_touch = |wr_hit[2*NCH-1:0] || |rd_hit[2*NCH-1:0];
  assign wsel       = wdata[CW-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel, hold;
    assign sel  = (xfer_ch == CW'(g));
    assign hold = (g == 0) && cmd_q[0] && cmd_q[1];
    dma_chan u_ch (
      .clk(clk), .rst(rst),
      .we_addr(wr_hit[2*g]), .we_cnt(wr_hit[2*g+1]),
      .bp_hi(bp), .wbyte(wdata),
      .step(xfer_step && sel), .abort(xfer_abort && sel),
      .autoinit(mode_q[g][M_AUTO]), .down(mode_q[g][M_DOWN]), .hold(hold),
      .cur_addr(ca[g]), .cur_cnt(cc[g]), .tc_now(tc_raw[g])
    );
  end

  // a memory-to-memory pair reports completion on channel 1 only
  always_comb begin
    tc_set = tc_raw;
    for (int c = 0; c < NCH; c++)
      if (xfer_abort && xfer_ch == CW'(c)) tc_set[c] = 1'b1;
    if (cmd_q[0]) begin
      tc_set[1] = tc_set[0] || tc_set[1];
      tc_set[0] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      cmd_q    <= '0;
      swreq_q  <= '0;
      mask_q   <= '1;
      tc_q     <= '0;
      tmp_q    <= '0;
      bp       <= 1'b0;
      mode_ptr <= '0;
    end else begin
      if (wr_hit[IX_STAT]) cmd_q <= wdata;
      if (wr_hit[IX_REQ])  swreq_q[wsel] <= wdata[2];
      if (wr_hit[IX_MBIT]) mask_q[wsel] <= wdata[2];
      if (wr_hit[IX_MCLR]) mask_q <= '0;
      if (wr_hit[IX_MASK]) mask_q <= wdata[NCH-1:0];
      tc_q <= (rd_hit[IX_STAT] ? '0 : tc_q) | tc_set;
      if (tmp_we) tmp_q <= tmp_din;
      if (wr_hit[IX_PTR])      bp <= 1'b0;
      else if (rd_hit[IX_PTR]) bp <= 1'b1;
      else if (chan_touch)     bp <= !bp;
      if (rd_hit[IX_MCLR])      mode_ptr <= '0;
      else if (rd_hit[IX_MODE]) mode_ptr <= mode_ptr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) mode_q[c] <= '0;
    end else if (wr_hit[IX_MODE]) begin
      mode_q[wsel] <= wdata[BYTE_W-1:2];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < AW'(2*NCH)) begin
      rdata = get_byte(addr[0] ? cc[addr[CW:1]] : ca[addr[CW:1]], bp);
    end else begin
      case (int'(addr))
        IX_STAT: rdata = {req_lvl, tc_q};
        IX_REQ:  rdata = {{(BYTE_W-NCH){1'b1}}, swreq_q};
        IX_MBIT: rdata = cmd_q;
        IX_MODE: rdata = {mode_q[mode_ptr], 2'b11};
        IX_TMP:  rdata = tmp_q;
        IX_MASK: rdata = {{(BYTE_W-NCH){1'b1}}, mask_q};
        default: rdata = '0;
      endcase
    end
  end

  assign xfer_addr = ca[xfer_ch];
  assign xfer_cnt  = cc[xfer_ch];
  assign xfer_mode = mode_q[xfer_ch];
  assign tc_pulse  = |tc_raw;

  a_r1_clear_mask: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (mask_q == '1 && cmd_q == '0 && !bp));
  a_r2_ptr_toggle: assert property (@(posedge clk) disable iff (rst)
    (chan_touch && !mclr) |=> bp != $past(bp));
  a_r7_status_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_hit[IX_STAT] && tc_set == '0) |=> tc_q == '0);
  a_r11_ch0_silent: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[0] && !wr_hit[IX_STAT] && !mclr && $past(tc_q[0]) == 1'b0) |=> !tc_q[0]);
endmodule

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  req_lvl = '0;
  logic [1:0]  xfer_ch = '0;
  logic        xfer_step = 1'b0, xfer_abort = 1'b0, tmp_we = 1'b0;
  logic [7:0]  tmp_din = '0;
  logic [15:0] xfer_addr, xfer_cnt;
  logic [5:0]  xfer_mode;
  logic        tc_pulse;
  logic [7:0]  cmd_q;
  logic [3:0]  mask_q, swreq_q;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = !clk;

  dma_regbank dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .req_lvl(req_lvl),
    .xfer_ch(xfer_ch), .xfer_step(xfer_step), .xfer_abort(xfer_abort),
    .tmp_we(tmp_we), .tmp_din(tmp_din), .xfer_addr(xfer_addr),
    .xfer_cnt(xfer_cnt), .xfer_mode(xfer_mode), .tc_pulse(tc_pulse),
    .cmd_q(cmd_q), .mask_q(mask_q), .swreq_q(swreq_q)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d, input int hold = 1);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    chk(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic pulse(input logic [1:0] ch, input bit abort, output logic tc);
    @(negedge clk);
    xfer_ch = ch;
    if (abort) xfer_abort = 1'b1; else xfer_step = 1'b1;
    #1 tc = tc_pulse;
    @(negedge clk);
    xfer_step = 1'b0; xfer_abort = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    bus_wr(4'hC, 8'h00);
    bus_wr(a, v[7:0]);
    bus_wr(a, v[15:8]);
  endtask

  task automatic rd16_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [7:0] lo, hi;
    bus_wr(4'hC, 8'h00);
    bus_rd(a, lo);
    bus_rd(a, hi);
    chk(req, {hi, lo}, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 mask after reset", 4'hF, 8'hFF);
    rd_chk("R1 status after reset", 4'h8, 8'h00);
    rd_chk("R1 command after reset", 4'hA, 8'h00);
  endtask

  task automatic t_pointer;
    logic [7:0] d;
    bus_wr(4'hC, 8'hAA);
    bus_wr(4'h2, 8'h34);
    bus_wr(4'h2, 8'h12, 3);           // R4: held strobe, one byte only
    rd_chk("R3 ch1 addr low", 4'h2, 8'h34);
    rd_chk("R4 ch1 addr high", 4'h2, 8'h12);
    bus_wr(4'hC, 8'h00);
    bus_rd(4'hC, d);                  // set pointer
    rd_chk("R2 set pointer gives high", 4'h2, 8'h12);
    rd_chk("R2 pointer toggles to low", 4'h2, 8'h34);
  endtask

  task automatic t_step_up;
    logic tc;
    wr16(4'h3, 16'h0005);
    bus_wr(4'hB, 8'h41);
    pulse(2'd1, 1'b0, tc);
    chk("R9 no tc at count 5", {15'd0, tc}, 16'd0);
    rd16_chk("R8 address up", 4'h2, 16'h1235);
    rd16_chk("R9 count down", 4'h3, 16'h0004);
  endtask

  task automatic t_wrap_down;
    logic tc;
    bus_wr(4'hB, 8'h62);
    wr16(4'h4, 16'h1000);
    wr16(4'h5, 16'h0000);
    pulse(2'd2, 1'b0, tc);
    chk("R9 tc pulse at zero", {15'd0, tc}, 16'd1);
    rd_chk("R7 status tc ch2", 4'h8, 8'h04);
    rd_chk("R7 status cleared by read", 4'h8, 8'h00);
    rd16_chk("R8 address down", 4'h4, 16'h0FFF);
    rd16_chk("R9 count wraps", 4'h5, 16'hFFFF);
  endtask

  task automatic t_autoinit;
    logic tc;
    bus_wr(4'hB, 8'h13);
    wr16(4'h6, 16'h0100);
    wr16(4'h7, 16'h0001);
    pulse(2'd3, 1'b0, tc);
    pulse(2'd3, 1'b0, tc);
    chk("R10 tc on second step", {15'd0, tc}, 16'd1);
    rd16_chk("R10 address reloaded", 4'h6, 16'h0100);
    rd16_chk("R10 count reloaded", 4'h7, 16'h0001);
    rd_chk("R10 status ch3", 4'h8, 8'h08);
    pulse(2'd3, 1'b0, tc);
    pulse(2'd3, 1'b1, tc);
    rd16_chk("R10 abort reloads address", 4'h6, 16'h0100);
    rd16_chk("R10 abort reloads count", 4'h7, 16'h0001);
    rd_chk("R10 abort sets flag", 4'h8, 8'h08);
  endtask

  task automatic t_m2m;
    logic tc;
    bus_wr(4'h8, 8'h03);
    bus_wr(4'hB, 8'h00);
    wr16(4'h0, 16'h0050);
    wr16(4'h1, 16'h0000);
    pulse(2'd0, 1'b0, tc);
    rd_chk("R11 only ch1 flag", 4'h8, 8'h02);
    rd16_chk("R8 ch0 address held", 4'h0, 16'h0050);
    rd_chk("R6 command readback", 4'hA, 8'h03);
    chk("R6 command port", {8'h00, cmd_q}, 16'h0003);
  endtask

  task automatic t_modes;
    logic [7:0] d;
    bus_rd(4'hE, d);
    rd_chk("R5 mode ch0", 4'hB, 8'h03);
    rd_chk("R5 mode ch1", 4'hB, 8'h43);
    rd_chk("R5 mode ch2", 4'hB, 8'h63);
    rd_chk("R5 mode ch3", 4'hB, 8'h13);
    rd_chk("R5 counter wraps to ch0", 4'hB, 8'h03);
  endtask

  task automatic t_req_mask;
    bus_wr(4'h9, 8'h06);
    rd_chk("R6 request set", 4'h9, 8'hF4);
    chk("R6 request port", {12'd0, swreq_q}, 16'h0004);
    bus_wr(4'h9, 8'h02);
    rd_chk("R6 request cleared", 4'h9, 8'hF0);
    bus_wr(4'hA, 8'h01);
    rd_chk("R6 mask bit cleared", 4'hF, 8'hFD);
    bus_wr(4'hE, 8'h55);
    rd_chk("R6 clear mask", 4'hF, 8'hF0);
    bus_wr(4'hF, 8'hA5);
    rd_chk("R6 full mask write", 4'hF, 8'hF5);
    chk("R6 mask port", {12'd0, mask_q}, 16'h0005);
  endtask

  task automatic t_temp_status;
    @(negedge clk);
    tmp_we = 1'b1; tmp_din = 8'hA5;
    @(negedge clk);
    tmp_we = 1'b0;
    rd_chk("R12 temp readback", 4'hD, 8'hA5);
    req_lvl = 4'h9;
    rd_chk("R7 raw request bits", 4'h8, 8'h90);
    req_lvl = 4'h0;
  endtask

  task automatic t_mclr;
    logic [7:0] d;
    bus_wr(4'h9, 8'h05);
    bus_rd(4'hC, d);
    bus_wr(4'hD, 8'h00);
    rd_chk("R1 mclr mask", 4'hF, 8'hFF);
    rd_chk("R1 mclr command", 4'hA, 8'h00);
    rd_chk("R1 mclr temp", 4'hD, 8'h00);
    rd_chk("R1 mclr request", 4'h9, 8'hF0);
    rd_chk("R1 mclr pointer low", 4'h2, 8'h35);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pointer();
    t_step_up();
    t_wrap_down();
    t_autoinit();
    t_m2m();
    t_modes();
    t_req_mask();
    t_temp_status();
    t_mclr();
    done = 1;
    finish_up();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end
endmodule